// File: doc/BRIEF.md
# Interrupt Priority Selection Unit

This block picks the one interrupt that a single target context should take next. Several vectors describe each source: pending, claimed and enabled. Each source also has a priority, and the context has a threshold. The block scans the sources one 32-bit word per clock. It keeps a running best candidate and, once the last word has been seen, reports the winning source ID and an interrupt request level on a one-cycle done pulse.

A scan begins on a start pulse while the unit is idle. The caller keeps all inputs steady until done arrives. The ID and level stay on the outputs until the next scan finishes. Register access, the capture of pending edges and claim tracking belong to the surrounding controller. The number of sources and the priority width are parameters; the word count is derived from the source count.

Top module: `irqsel_top`

## Requirements
- R1: A source can win only while its pending bit is 1, its claimed bit is 0 and its enable bit is 1; clearing any one of the three removes it from the selection.
- R2: A candidate can win only if its priority is strictly greater than the threshold; a priority equal to the threshold never wins.
- R3: Among candidates with the same highest priority, the lowest source ID wins, including when they lie in different words.
- R4: Source n is bit n of each flat vector and occupies bits n*PRIO_W and up of the priority vector. The scan treats bit n as word n/32, position n mod 32, and the result is the full ID n.
- R5: A result ID of 0 means no interrupt, and the request output irq_o is 1 exactly when id_o is nonzero.
- R6: Source 0 is reserved and is never reported, whatever its pending, enable and priority inputs are.
- R7: done_o is a one-cycle pulse exactly NWORDS clock cycles after the edge that accepts start_i. id_o and irq_o change only together with done_o.
- R8: A start_i pulse that arrives while a scan is in progress is ignored: the running scan ends on schedule and produces a single done pulse.
- R9: After a synchronous reset, done_o, id_o and irq_o are all 0.
- R10: Words that hold no candidate leave the running best unchanged, so a winner found in an early word survives empty later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan when idle |
| pend_i | input | NSRC | Pending bit per source |
| claim_i | input | NSRC | Claimed bit per source |
| en_i | input | NSRC | Enable bit per source for this context |
| prio_i | input | NSRC*PRIO_W | Priority per source, source n at bits n*PRIO_W and up |
| thresh_i | input | PRIO_W | Context threshold |
| done_o | output | 1 | One-cycle result pulse |
| id_o | output | ID_W | Winning source ID, 0 for none |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the unit with 70 sources and a 3-bit priority. That makes three words, and the last one is only partly filled. It exercises the word counter beyond a single step, ties that cross word boundaries, the highest real source (69) and the padding bits. The 3-bit priority keeps thresholds and equal-priority collisions common in random draws, so the strict-greater rule and lowest-ID tie breaking come up often.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int WORD_BITS = 32;
    localparam int BIT_IDX_W = 5;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } scan_st_e;

    function automatic int words_for(int nsrc);
        return (nsrc + WORD_BITS - 1) / WORD_BITS;
    endfunction

    function automatic int idx_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irqsel_word_pick.sv
module irqsel_word_pick #(
    parameter int PRIO_W = 3
) (
    input  logic [31:0]           cand_i,
    input  logic [32*PRIO_W-1:0]  prio_i,
    input  logic [PRIO_W-1:0]     floor_i,
    output logic                  hit_o,
    output logic [4:0]            bit_o,
    output logic [PRIO_W-1:0]     prio_o
);
    // Ascending bit order with a strict compare keeps the lowest index on ties.
    always_comb begin
        hit_o  = 1'b0;
        bit_o  = '0;
        prio_o = floor_i;
        if (|cand_i) begin
            for (int j = 0; j < 32; j++) begin
                if (cand_i[j] && (prio_i[j*PRIO_W +: PRIO_W] > prio_o)) begin
                    hit_o  = 1'b1;
                    bit_o  = 5'(j);
                    prio_o = prio_i[j*PRIO_W +: PRIO_W];
                end
            end
        end
    end
endmodule

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl
    import irqsel_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              first_o,
    output logic              last_o,
    output logic [WIDX_W-1:0] widx_o
);
    scan_st_e          st;
    logic [WIDX_W-1:0] widx;

    assign busy_o  = (st == ST_SCAN);
    assign first_o = busy_o && (widx == '0);
    assign last_o  = busy_o && (widx == WIDX_W'(NWORDS - 1));
    assign widx_o  = widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            widx <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st   <= ST_SCAN;
                        widx <= '0;
                    end
                end
                ST_SCAN: begin
                    if (last_o) begin
                        st <= ST_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 3,
    localparam int NWORDS = words_for(NSRC),
    localparam int WIDX_W = idx_bits(NWORDS),
    localparam int ID_W   = WIDX_W + BIT_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NSRC-1:0]        pend_i,
    input  logic [NSRC-1:0]        claim_i,
    input  logic [NSRC-1:0]        en_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thresh_i,
    output logic                   done_o,
    output logic [ID_W-1:0]        id_o,
    output logic                   irq_o
);
    localparam int PADW = NWORDS * WORD_BITS;

    logic                busy, first, last;
    logic [WIDX_W-1:0]   widx;
    logic [PADW-1:0]     cand_all;
    logic [PADW*PRIO_W-1:0] prio_all;
    logic [31:0]         cand_w;
    logic [32*PRIO_W-1:0] prio_w;
    logic [PRIO_W-1:0]   floor_prio, w_prio, best_prio;
    logic [ID_W-1:0]     best_id, base_id, nxt_id;
    logic                w_hit;
    logic [4:0]          w_bit;

    // Eligibility per source; source 0 and padding positions never qualify.
    for (genvar n = 0; n < PADW; n++) begin : g_cand
        if (n == 0 || n >= NSRC) begin : g_off
            assign cand_all[n] = 1'b0;
            assign prio_all[n*PRIO_W +: PRIO_W] = '0;
        end else begin : g_on
            assign cand_all[n] = pend_i[n] & ~claim_i[n] & en_i[n];
            assign prio_all[n*PRIO_W +: PRIO_W] = prio_i[n*PRIO_W +: PRIO_W];
        end
    end

    assign cand_w = cand_all[{widx, 5'd0} +: 32];
    assign prio_w = prio_all[int'(widx)*32*PRIO_W +: 32*PRIO_W];

    irqsel_ctrl #(
        .NWORDS (NWORDS),
        .WIDX_W (WIDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_o  (busy),
        .first_o (first),
        .last_o  (last),
        .widx_o  (widx)
    );

    assign floor_prio = first ? thresh_i : best_prio;
    assign base_id    = first ? '0 : best_id;

    irqsel_word_pick #(
        .PRIO_W (PRIO_W)
    ) u_pick (
        .cand_i  (cand_w),
        .prio_i  (prio_w),
        .floor_i (floor_prio),
        .hit_o   (w_hit),
        .bit_o   (w_bit),
        .prio_o  (w_prio)
    );

    assign nxt_id = w_hit ? {widx, w_bit} : base_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_prio <= '0;
            best_id   <= '0;
            done_o    <= 1'b0;
            id_o      <= '0;
            irq_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (busy) begin
                best_prio <= w_prio;
                best_id   <= nxt_id;
                if (last) begin
                    done_o <= 1'b1;
                    id_o   <= nxt_id;
                    irq_o  <= (nxt_id != '0);
                end
            end
        end
    end
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   busy,
    input logic [NSRC-1:0]        pend_i,
    input logic [NSRC-1:0]        claim_i,
    input logic [NSRC-1:0]        en_i,
    input logic [NSRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]      thresh_i,
    input logic                   done_o,
    input logic [ID_W-1:0]        id_o,
    input logic                   irq_o
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_after_scan_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(busy));

    assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (id_o == $past(id_o)) && (irq_o == $past(irq_o)));

    assert_level_matches_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o == (id_o != '0));

    assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && irq_o) |-> (pend_i[id_o] && !claim_i[id_o] && en_i[id_o]));

    assert_above_threshold_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && irq_o) |-> (prio_i[int'(id_o)*PRIO_W +: PRIO_W] > thresh_i));

    assert_id_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && irq_o) |-> (int'(id_o) < NSRC));
endmodule

bind irqsel_top irqsel_chk #(
    .NSRC   (NSRC),
    .PRIO_W (PRIO_W),
    .ID_W   (ID_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .pend_i   (pend_i),
    .claim_i  (claim_i),
    .en_i     (en_i),
    .prio_i   (prio_i),
    .thresh_i (thresh_i),
    .done_o   (done_o),
    .id_o     (id_o),
    .irq_o    (irq_o)
);

// File: tb/tb_irqsel_top.sv
`timescale 1ns/1ps
module tb_irqsel_top;
    localparam int NSRC   = 70;
    localparam int PRIO_W = 3;
    localparam int NWORDS = 3;
    localparam int ID_W   = 7;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start_i = 1'b0;
    logic [NSRC-1:0]        pend_i = '0;
    logic [NSRC-1:0]        claim_i = '0;
    logic [NSRC-1:0]        en_i = '0;
    logic [NSRC*PRIO_W-1:0] prio_i = '0;
    logic [PRIO_W-1:0]      thresh_i = '0;
    logic                   done_o;
    logic [ID_W-1:0]        id_o;
    logic                   irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irqsel_top #(.NSRC(NSRC), .PRIO_W(PRIO_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .pend_i(pend_i), .claim_i(claim_i), .en_i(en_i),
        .prio_i(prio_i), .thresh_i(thresh_i),
        .done_o(done_o), .id_o(id_o), .irq_o(irq_o)
    );

    // Stimulus table: {mode, threshold, seed}. Modes: 0 dense random,
    // 1 sparse random, 2 all priorities threshold+1, 3 all equal to threshold.
    localparam logic [47:0] TBL [12] = '{
        {8'd0, 8'd0, 32'h1234_5678}, {8'd0, 8'd3, 32'h0BAD_F00D},
        {8'd0, 8'd6, 32'h7777_1111}, {8'd1, 8'd0, 32'hCAFE_0001},
        {8'd1, 8'd2, 32'h5150_2A2A}, {8'd2, 8'd0, 32'h0F0F_F0F0},
        {8'd2, 8'd4, 32'h1357_9BDF}, {8'd3, 8'd1, 32'h2468_ACE0},
        {8'd3, 8'd5, 32'h0000_BEEF}, {8'd0, 8'd1, 32'hDEAD_0042},
        {8'd1, 8'd0, 32'h3141_5926}, {8'd2, 8'd6, 32'h2718_2818}
    };

    function automatic logic [31:0] xs(logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [ID_W-1:0] ref_pick();
        logic [ID_W-1:0]   best = '0;
        logic [PRIO_W-1:0] bp   = thresh_i;
        for (int n = 1; n < NSRC; n++) begin
            if (pend_i[n] && !claim_i[n] && en_i[n] &&
                prio_i[n*PRIO_W +: PRIO_W] > bp) begin
                best = ID_W'(n);
                bp   = prio_i[n*PRIO_W +: PRIO_W];
            end
        end
        return best;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        pend_i = '0; claim_i = '0; en_i = '0; prio_i = '0; thresh_i = '0;
    endtask

    task automatic set_src(int n, logic [PRIO_W-1:0] p);
        pend_i[n] = 1'b1; en_i[n] = 1'b1; claim_i[n] = 1'b0;
        prio_i[n*PRIO_W +: PRIO_W] = p;
    endtask

    // Pulse start, measure latency, check pulse width and result.
    task automatic run(string req, logic [ID_W-1:0] exp_id, bit restart);
        int lat = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = restart;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        check({req, " latency R7"}, 32'(lat), 32'(NWORDS));
        check({req, " id"}, 32'(id_o), 32'(exp_id));
        check({req, " level R5"}, 32'(irq_o), 32'(exp_id != '0));
        @(negedge clk);
        check({req, " pulse R7"}, 32'(done_o), 32'd0);
    endtask

    task automatic gen(logic [7:0] mode, logic [PRIO_W-1:0] thr, logic [31:0] seed);
        logic [31:0] s = seed;
        thresh_i = thr;
        for (int n = 0; n < NSRC; n++) begin
            s = xs(s);
            pend_i[n]  = (mode == 8'd1) ? (s[0] & s[5] & s[6]) : s[0];
            claim_i[n] = s[1] & s[2];
            en_i[n]    = s[3] | s[4];
            case (mode)
                8'd2:    prio_i[n*PRIO_W +: PRIO_W] = thr + 1'b1;
                8'd3:    prio_i[n*PRIO_W +: PRIO_W] = thr;
                default: prio_i[n*PRIO_W +: PRIO_W] = s[10:8];
            endcase
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 done", 32'(done_o), 0);
        check("R9 id", 32'(id_o), 0);
        check("R9 irq", 32'(irq_o), 0);
        rst = 1'b0;

        // Table walk against the reference loop (R1, R2, R3, R4, R10)
        for (int k = 0; k < 12; k++) begin
            gen(TBL[k][47:40], TBL[k][34:32], TBL[k][31:0]);
            run($sformatf("table%0d R1 R2 R3", k), ref_pick(), 1'b0);
        end

        // R6: only source 0 active at top priority
        clear_inputs(); set_src(0, 3'd7);
        run("R6 src0", '0, 1'b0);

        // R1: each of the three conditions removes a source
        clear_inputs(); set_src(5, 3'd2); claim_i[5] = 1'b1;
        run("R1 claimed", '0, 1'b0);
        claim_i[5] = 1'b0;
        run("R1 eligible", 7'd5, 1'b0);
        en_i[5] = 1'b0;
        run("R1 disabled", '0, 1'b0);
        en_i[5] = 1'b1; pend_i[5] = 1'b0;
        run("R1 not pending", '0, 1'b0);

        // R2: equal to threshold loses, one above wins
        clear_inputs(); set_src(40, 3'd3); thresh_i = 3'd3;
        run("R2 equal", '0, 1'b0);
        thresh_i = 3'd2;
        run("R2 above", 7'd40, 1'b0);

        // R3: tie across words goes to lowest ID
        clear_inputs(); set_src(64, 3'd5); set_src(33, 3'd5); set_src(10, 3'd4);
        run("R3 tie", 7'd33, 1'b0);

        // R4: word boundaries and highest source
        clear_inputs(); set_src(69, 3'd1);
        run("R4 src69", 7'd69, 1'b0);
        clear_inputs(); set_src(32, 3'd1); set_src(31, 3'd1);
        run("R4 src31", 7'd31, 1'b0);

        // R10: winner in word 0 survives empty later words
        clear_inputs(); set_src(7, 3'd6);
        run("R10 early", 7'd7, 1'b0);

        // R8: start held into the scan is ignored, one done only
        clear_inputs(); set_src(50, 3'd4);
        run("R8 restart", 7'd50, 1'b1);
        begin
            int extra = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R8 no second done", 32'(extra), 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule